// File: doc/BRIEF.md
# Integer Arithmetic and Logic Unit

This block is the execution unit of a 32-bit integer datapath. It takes two operands that upstream logic has already prepared (sign or zero extension has been done) and a 4-bit operation code. From these it forms a 32-bit result, a carry-out flag and a signed-overflow flag. It supports signed and unsigned addition and subtraction, four bitwise operations, and signed and unsigned set-on-less-than.

The unit has no clock and no state. Every output is a pure function of the present inputs. All arithmetic, including both comparisons, shares one adder. For subtraction and comparison, that adder sees the inverted second operand and a carry-in of one. A signed comparison reads the sign of the difference corrected by the overflow bit. An unsigned comparison reads the missing carry-out, which marks a borrow.

Top module: `int_alu`

## Requirements
- R1: Operation code 0 (add) and 1 (add unsigned) return the low 32 bits of opa_i + opb_i, and carry_o is bit 32 of that sum.
- R2: Operation code 2 (subtract) and 3 (subtract unsigned) return the low 32 bits of opa_i + ~opb_i + 1. carry_o is the carry out of bit 31, so it is 1 exactly when opa_i >= opb_i taken as unsigned numbers.
- R3: ovf_o is 1 in codes 0 and 2 exactly when the two's-complement result does not fit in 32 bits. It is always 0 in codes 1 and 3.
- R4: Codes 4, 5, 6 and 7 return the bitwise AND, OR, XOR and NOR of the operands across all 32 bits, with carry_o = 0 and ovf_o = 0.
- R5: Code 10 returns 1 in bit 0 when opa_i < opb_i taken as signed numbers, and 0 otherwise. Bits 31..1 are 0, carry_o = 0 and ovf_o = 0. The result is correct even when the internal difference overflows.
- R6: Code 11 returns 1 in bit 0 when opa_i < opb_i taken as unsigned numbers, and 0 otherwise. Bits 31..1 are 0, carry_o = 0 and ovf_o = 0.
- R7: Codes 8, 9, 12, 13, 14 and 15 return an all-zero result with carry_o = 0 and ovf_o = 0, whatever the operands are.
- R8: The unit is combinational. A change on any input shows on the outputs in the same time step, without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | 32 | First operand |
| opb_i | input | 32 | Second operand |
| mode_i | input | 4 | Operation code |
| result_o | output | 32 | Operation result |
| carry_o | output | 1 | Adder carry out (arithmetic codes only) |
| ovf_o | output | 1 | Signed overflow (codes 0 and 2 only) |

## Verification
The bench targets several boundary cases, each of which catches a specific mistake:
- Adding 0x7FFFFFFF and 1, and adding two values with the top bit set. A design that derives overflow from the carry alone flags the wrong one of these.
- Subtracting a value from itself. A missing carry-in of one shows up here as a wrong difference, and carry_o fails to read 1.
- Comparing 0x80000000 against 1, and 0x7FFFFFFF against 0xFFFFFFFF, in both comparison codes. A design that reads the raw sign bit without the overflow correction answers the signed case backwards, and one that swaps the borrow sense breaks the unsigned case.
- Unsigned arithmetic on overflowing operands, and every unused code with all-ones operands. These expose an overflow or result path that leaks into modes where it must stay quiet.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;

    localparam int MODE_W = 4;

    localparam logic [MODE_W-1:0] OP_ADD  = 4'd0;
    localparam logic [MODE_W-1:0] OP_ADDU = 4'd1;
    localparam logic [MODE_W-1:0] OP_SUB  = 4'd2;
    localparam logic [MODE_W-1:0] OP_SUBU = 4'd3;
    localparam logic [MODE_W-1:0] OP_AND  = 4'd4;
    localparam logic [MODE_W-1:0] OP_OR   = 4'd5;
    localparam logic [MODE_W-1:0] OP_XOR  = 4'd6;
    localparam logic [MODE_W-1:0] OP_NOR  = 4'd7;
    localparam logic [MODE_W-1:0] OP_SLT  = 4'd10;
    localparam logic [MODE_W-1:0] OP_SLTU = 4'd11;

    typedef enum logic [1:0] {
        BW_AND = 2'd0,
        BW_OR  = 2'd1,
        BW_XOR = 2'd2,
        BW_NOR = 2'd3
    } bw_sel_e;

    typedef struct packed {
        logic    arith_en;   // drive sum and carry to the outputs
        logic    bitwise_en; // drive the bitwise unit to the outputs
        logic    setlt_en;   // drive a comparison bit to the outputs
        logic    invert_b;   // subtract: invert B and carry in one
        logic    ovf_en;     // signed arithmetic reports overflow
        logic    setlt_uns;  // comparison uses the borrow, not the sign
        bw_sel_e bw_sel;
    } alu_ctl_t;

endpackage

// File: rtl/int_alu_decode.sv
module int_alu_decode
    import int_alu_pkg::*;
(
    input  logic [MODE_W-1:0] mode_i,
    output alu_ctl_t          ctl_o
);

    alu_ctl_t ctl_d;

    always_comb begin
        ctl_d = '0;
        ctl_d.bw_sel = BW_AND;
        case (mode_i)
            OP_ADD:  begin ctl_d.arith_en = 1'b1; ctl_d.ovf_en = 1'b1; end
            OP_ADDU: begin ctl_d.arith_en = 1'b1; end
            OP_SUB:  begin ctl_d.arith_en = 1'b1; ctl_d.invert_b = 1'b1;
                           ctl_d.ovf_en = 1'b1; end
            OP_SUBU: begin ctl_d.arith_en = 1'b1; ctl_d.invert_b = 1'b1; end
            OP_AND:  begin ctl_d.bitwise_en = 1'b1; ctl_d.bw_sel = BW_AND; end
            OP_OR:   begin ctl_d.bitwise_en = 1'b1; ctl_d.bw_sel = BW_OR;  end
            OP_XOR:  begin ctl_d.bitwise_en = 1'b1; ctl_d.bw_sel = BW_XOR; end
            OP_NOR:  begin ctl_d.bitwise_en = 1'b1; ctl_d.bw_sel = BW_NOR; end
            OP_SLT:  begin ctl_d.setlt_en = 1'b1; ctl_d.invert_b = 1'b1; end
            OP_SLTU: begin ctl_d.setlt_en = 1'b1; ctl_d.invert_b = 1'b1;
                           ctl_d.setlt_uns = 1'b1; end
            default: ctl_d = '0;
        endcase
    end

    assign ctl_o = ctl_d;

endmodule

// File: rtl/int_alu_adder.sv
module int_alu_adder #(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o,
    output logic         ovf_o
);

    logic [W:0] carry_d;

    assign carry_d[0] = cin_i;

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic prop_d;
        assign prop_d         = a_i[i] ^ b_i[i];
        assign sum_o[i]       = prop_d ^ carry_d[i];
        assign carry_d[i + 1] = (a_i[i] & b_i[i]) | (prop_d & carry_d[i]);
    end

    assign cout_o = carry_d[W];
    // signed overflow: carry into the sign bit differs from carry out of it
    assign ovf_o  = carry_d[W] ^ carry_d[W - 1];

endmodule

// File: rtl/int_alu_bitwise.sv
module int_alu_bitwise
    import int_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  bw_sel_e      sel_i,
    output logic [W-1:0] y_o
);

    logic [W-1:0] y_d;

    always_comb begin
        case (sel_i)
            BW_AND:  y_d = a_i & b_i;
            BW_OR:   y_d = a_i | b_i;
            BW_XOR:  y_d = a_i ^ b_i;
            default: y_d = ~(a_i | b_i);
        endcase
    end

    assign y_o = y_d;

endmodule

// File: rtl/int_alu.sv
module int_alu
    import int_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0]      opa_i,
    input  logic [W-1:0]      opb_i,
    input  logic [MODE_W-1:0] mode_i,
    output logic [W-1:0]      result_o,
    output logic              carry_o,
    output logic              ovf_o
);

    localparam int PAD_W = W - 1;

    typedef struct packed {
        logic [W-1:0] res;
        logic         carry;
        logic         ovf;
    } alu_out_t;

    alu_ctl_t     ctl_d;
    logic [W-1:0] addb_d;
    logic [W-1:0] sum_d;
    logic         cout_d;
    logic         vraw_d;
    logic [W-1:0] bw_d;
    logic         less_d;
    alu_out_t     out_d;

    int_alu_decode u_decode (
        .mode_i (mode_i),
        .ctl_o  (ctl_d)
    );

    assign addb_d = ctl_d.invert_b ? ~opb_i : opb_i;

    int_alu_adder #(.W(W)) u_adder (
        .a_i    (opa_i),
        .b_i    (addb_d),
        .cin_i  (ctl_d.invert_b),
        .sum_o  (sum_d),
        .cout_o (cout_d),
        .ovf_o  (vraw_d)
    );

    int_alu_bitwise #(.W(W)) u_bitwise (
        .a_i   (opa_i),
        .b_i   (opb_i),
        .sel_i (ctl_d.bw_sel),
        .y_o   (bw_d)
    );

    // unsigned: no carry out means a borrow; signed: sign corrected by overflow
    assign less_d = ctl_d.setlt_uns ? ~cout_d : (sum_d[W-1] ^ vraw_d);

    always_comb begin
        out_d = '0;
        if (ctl_d.arith_en) begin
            out_d.res   = sum_d;
            out_d.carry = cout_d;
            out_d.ovf   = ctl_d.ovf_en & vraw_d;
        end else if (ctl_d.bitwise_en) begin
            out_d.res = bw_d;
        end else if (ctl_d.setlt_en) begin
            out_d.res = {{PAD_W{1'b0}}, less_d};
        end
    end

    assign result_o = out_d.res;
    assign carry_o  = out_d.carry;
    assign ovf_o    = out_d.ovf;

endmodule

// File: rtl/int_alu_chk.sv
module int_alu_chk
    import int_alu_pkg::*;
#(
    parameter int W = 32
) (
    input logic [W-1:0]      opa_i,
    input logic [W-1:0]      opb_i,
    input logic [MODE_W-1:0] mode_i,
    input logic [W-1:0]      result_o,
    input logic              carry_o,
    input logic              ovf_o
);

    logic known_d;
    logic [W:0] wide_sum_d;

    assign known_d    = !$isunknown({opa_i, opb_i, mode_i});
    assign wide_sum_d = {1'b0, opa_i} + {1'b0, opb_i};

    always_comb begin
        if (known_d) begin
            if (mode_i == OP_ADD || mode_i == OP_ADDU) begin
                p_add_sum_r1: assert ({carry_o, result_o} == wide_sum_d)
                    else $error("R1 sum mismatch");
            end
            if (mode_i == OP_ADDU || mode_i == OP_SUBU) begin
                p_no_overflow_r3: assert (!ovf_o)
                    else $error("R3 overflow in unsigned mode");
            end
            if (mode_i >= OP_AND && mode_i <= OP_NOR) begin
                p_bitwise_flags_r4: assert (!carry_o && !ovf_o)
                    else $error("R4 flag set in bitwise mode");
            end
            if (mode_i == OP_SLT || mode_i == OP_SLTU) begin
                p_setlt_zext_r5: assert (result_o[W-1:1] == '0 && !carry_o && !ovf_o)
                    else $error("R5/R6 comparison result not zero-extended");
            end
            if (mode_i == 4'd8 || mode_i == 4'd9 || mode_i >= 4'd12) begin
                p_unused_zero_r7: assert (result_o == '0 && !carry_o && !ovf_o)
                    else $error("R7 unused code produced output");
            end
        end
    end

endmodule

bind int_alu int_alu_chk #(.W(W)) u_chk (
    .opa_i    (opa_i),
    .opb_i    (opb_i),
    .mode_i   (mode_i),
    .result_o (result_o),
    .carry_o  (carry_o),
    .ovf_o    (ovf_o)
);

// File: tb/int_alu_bench.sv
module int_alu_bench;

    localparam int W = 32;

    logic         clk = 1'b0;
    logic [W-1:0] opa, opb;
    logic [3:0]   mode;
    logic [W-1:0] result;
    logic         carry, ovf;

    int n_vec  = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done   = 0;

    always #2 clk = ~clk;  // 250 MHz

    int_alu u_int_alu (
        .opa_i    (opa),
        .opb_i    (opb),
        .mode_i   (mode),
        .result_o (result),
        .carry_o  (carry),
        .ovf_o    (ovf)
    );

    // independent reference: {result, carry, overflow}
    function automatic logic [W+1:0] ref_alu(input logic [W-1:0] a, input logic [W-1:0] b,
                                             input logic [3:0] m);
        logic [W:0]   s;
        logic [W-1:0] r;
        logic         c, v;
        r = '0; c = 1'b0; v = 1'b0;
        case (m)
            4'd0, 4'd1: begin
                s = {1'b0, a} + {1'b0, b};
                r = s[W-1:0]; c = s[W];
                if (m == 4'd0) v = (a[W-1] == b[W-1]) && (r[W-1] != a[W-1]);
            end
            4'd2, 4'd3: begin
                s = {1'b0, a} + {1'b0, ~b} + 33'd1;
                r = s[W-1:0]; c = (a >= b);
                if (m == 4'd2) v = (a[W-1] != b[W-1]) && (r[W-1] != a[W-1]);
            end
            4'd4: r = a & b;
            4'd5: r = a | b;
            4'd6: r = a ^ b;
            4'd7: r = ~(a | b);
            4'd10: r = {31'd0, ($signed(a) < $signed(b))};
            4'd11: r = {31'd0, (a < b)};
            default: r = '0;
        endcase
        return {r, c, v};
    endfunction

    task automatic apply(input string tag, input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic [3:0] m);
        logic [W+1:0] e;
        opa = a; opb = b; mode = m;
        #1;
        e = ref_alu(a, b, m);
        n_vec++;
        if ({result, carry, ovf} !== e) begin
            n_fail++;
            $display("FAIL %s mode=%0d a=%h b=%h got res=%h c=%b v=%b exp res=%h c=%b v=%b",
                     tag, m, a, b, result, carry, ovf, e[W+1:2], e[1], e[0]);
        end
    endtask

    task automatic t_idle;
        apply("R1 idle", 32'h0, 32'h0, 4'd0);
    endtask

    task automatic t_add_r1;
        apply("R1", 32'hFFFF_FFFF, 32'h1, 4'd1);
        apply("R1", 32'h1234_5678, 32'h8765_4321, 4'd0);
        for (int i = 0; i < 300; i++) apply("R1", $urandom, $urandom, 4'($urandom_range(0, 1)));
    endtask

    task automatic t_sub_r2;
        apply("R2 self", 32'hDEAD_BEEF, 32'hDEAD_BEEF, 4'd2);
        apply("R2 borrow", 32'h0, 32'h1, 4'd3);
        apply("R2", 32'h5, 32'h3, 4'd3);
        for (int i = 0; i < 300; i++) apply("R2", $urandom, $urandom, 4'($urandom_range(2, 3)));
    endtask

    task automatic t_ovf_r3;
        apply("R3 pos", 32'h7FFF_FFFF, 32'h1, 4'd0);
        apply("R3 neg", 32'h8000_0000, 32'h8000_0000, 4'd0);
        apply("R3 sub", 32'h8000_0000, 32'h1, 4'd2);
        apply("R3 sub", 32'h7FFF_FFFF, 32'hFFFF_FFFF, 4'd2);
        apply("R3 addu", 32'h7FFF_FFFF, 32'h1, 4'd1);
        apply("R3 subu", 32'h8000_0000, 32'h1, 4'd3);
    endtask

    task automatic t_bitwise_r4;
        for (int m = 4; m < 8; m++) begin
            apply("R4", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'(m));
            apply("R4", 32'hF0F0_A5A5, 32'h0FF0_5A5A, 4'(m));
            for (int i = 0; i < 100; i++) apply("R4", $urandom, $urandom, 4'(m));
        end
    endtask

    task automatic t_slt_r5;
        apply("R5 ovf", 32'h8000_0000, 32'h1, 4'd10);
        apply("R5", 32'h7FFF_FFFF, 32'hFFFF_FFFF, 4'd10);
        apply("R5 eq", 32'h42, 32'h42, 4'd10);
        for (int i = 0; i < 300; i++) apply("R5", $urandom, $urandom, 4'd10);
    endtask

    task automatic t_sltu_r6;
        apply("R6", 32'h8000_0000, 32'h1, 4'd11);
        apply("R6", 32'h7FFF_FFFF, 32'hFFFF_FFFF, 4'd11);
        apply("R6 eq", 32'h0, 32'h0, 4'd11);
        for (int i = 0; i < 300; i++) apply("R6", $urandom, $urandom, 4'd11);
    endtask

    task automatic t_unused_r7;
        for (int m = 8; m < 16; m++) begin
            if (m == 10 || m == 11) continue;
            apply("R7", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'(m));
            apply("R7", 32'h8000_0000, 32'h7FFF_FFFF, 4'(m));
        end
    endtask

    task automatic t_comb_r8;
        // inputs change between clock edges; result expected 1 ns later
        @(posedge clk); #1;
        apply("R8", 32'h1, 32'h2, 4'd0);
        apply("R8", 32'h1, 32'h2, 4'd7);
        apply("R8", 32'h3, 32'h2, 4'd3);
    endtask

    initial begin
        opa = '0; opb = '0; mode = '0;
        t_idle();
        t_add_r1();
        t_sub_r2();
        t_ovf_r3();
        t_bitwise_r4();
        t_slt_r5();
        t_sltu_r6();
        t_unused_r7();
        t_comb_r8();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (!done && cycles > 100000) begin
            n_fail++;
            $display("FAIL watchdog expired got %0d cycles exp completion", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

endmodule